// File: doc/BRIEF.md
# Scrambled Bank Register Mapper

This block sits on the write side of an 8-bit CPU bus inside a cartridge-style memory system. It watches CPU writes, keeps a command register and eight bank slots, and turns the slots into the upper address bits for two memories. Six slots choose 1 KB banks of pattern memory, and two slots choose 8 KB banks of program memory. A mirroring select for the name-table layout is also held here.

A mode flag can make every bank number pass through a fixed bit shuffle as it is written. Pattern slots use a single permutation. Program slots use an offset-and-shuffle rule instead. The shuffle is applied when the value is stored, so a later change of the mode flag leaves banks that are already stored unchanged. Outputs are combinational from the stored state and the current address, so a write takes effect on the cycle after its clock edge.

Top module: `scramble_mapper`

## Requirements
- R1: After synchronous reset: the mode flag is off, the command register is 0, pattern slots 0 to 5 and program slot 6 hold 0, program slot 7 holds 1, and the mirroring output is 0 (vertical).
- R2: A write to address 0x5000 with data 0x00 turns the scramble mode off, and with data 0x02 turns it on. Any other data, or any other address, leaves the mode as it was.
- R3: Register decoding uses the address ANDed with 0xFF01. A result of 0x8000 or 0x8800 loads the command register. A result of 0x8001 or 0x8801 loads the bank slot whose index is the command's bits 2..0. Any other result leaves the slots and the command unchanged.
- R4: The pattern window index is ppu_page (address bits 12..10). Windows 0 and 1 use slot 0, with bit 0 forced to 0 and to 1 respectively. Windows 2 and 3 use slot 1 in the same way. Windows 4 to 7 use slots 2 to 5 unchanged.
- R5: In scramble mode, a value v written to slots 0 to 5 is stored as {v[5],v[4],v[2],v[6],v[7],v[3],v[1],v[0]} (bit 7 first).
- R6: In scramble mode, a value v written to slot 6 or 7 is stored as {3'b000,v[2],v[1],v[3],v[4],v[0]} when v < 0x20. Otherwise w = v - 0x20 is formed first, and the value is stored with the R5 shuffle of w.
- R7: The shuffle is applied when the value is written. Changing the mode later does not alter slots that are already stored.
- R8: The program window index is cpu_addr bits 14..13. Window 0 gives slot 6, window 1 gives slot 7, window 2 gives PRG_BANKS-2 and window 3 gives PRG_BANKS-1. Each value is cut to log2(PRG_BANKS) bits, so larger numbers wrap.
- R9: A write whose masked address is 0xA000 or 0xA800 sets mirror_horiz to data bit 0 (1 means horizontal). The write is ignored while four_screen is high.
- R10: Writes to 0x6000 to 0x7FFF change no mapper state (mode, command, slots or mirroring).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_we | input | 1 | CPU write strobe for this cycle |
| cpu_addr | input | 16 | CPU address, used for write decode and program window select |
| cpu_wdata | input | 8 | CPU write data |
| four_screen | input | 1 | Board has four name tables; locks the mirroring select |
| ppu_page | input | 3 | Pattern address bits 12..10 (1 KB window index) |
| chr_bank | output | 8 | 1 KB pattern bank number for the current window |
| prg_bank | output | PRG_W | 8 KB program bank number for the current CPU window |
| mirror_horiz | output | 1 | 1 selects horizontal mirroring, 0 selects vertical |

## Verification
All mapper state can be seen at the ports. A wrong mode flag, command or slot value appears on chr_bank or prg_bank as soon as the matching window is addressed, in the cycle after the faulty write. A mis-decoded address shows up as a window that changed when it should not have, or that did not change when it should have. A wrong shuffle gives a bank number with bits in the wrong places. The sweeps cover every byte in both modes, so a single swapped or stuck bit is seen on the first value that exercises it.

// File: rtl/smap_pkg.sv
// Shared types and the two bank-number shuffles of the mapper.
// Assumes 8-bit bank values; all users import this package.
package smap_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_SLOTS = 8;
    localparam int SEL_W     = $clog2(NUM_SLOTS);
    localparam int PRG_LO    = 6;   // first program slot
    localparam int PRG_HI    = 7;   // second program slot

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_MODE,
        K_CMD,
        K_BANK,
        K_MIRROR
    } wr_kind_t;

    // Pattern shuffle: new bit order 5,4,2,6,7,3,1,0 (msb first).
    function automatic bank_t shuffle_pat(input bank_t v);
        return {v[5], v[4], v[2], v[6], v[7], v[3], v[1], v[0]};
    endfunction

    // Program shuffle: small values use a 5-bit reorder, others are offset then pattern-shuffled.
    function automatic bank_t shuffle_prg(input bank_t v);
        bank_t t;
        if (v < 8'h20) begin
            t = {3'b000, v[2], v[1], v[3], v[4], v[0]};
        end else begin
            t = shuffle_pat(v - 8'h20);
        end
        return t;
    endfunction

endpackage

// File: rtl/smap_decode.sv
// Write decoder: classifies one CPU write into a register target.
// Assumes a single-cycle write strobe; the mode port is matched on the
// full address, the mapper registers on the address ANDed with 0xFF01.
module smap_decode
    import smap_pkg::*;
#(
    parameter logic [15:0] MODE_ADDR = 16'h5000,
    parameter logic [15:0] REG_MASK  = 16'hFF01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] addr,
    output wr_kind_t    kind
);

    logic [15:0] masked;
    assign masked = addr & REG_MASK;

    // Map the strobe and address onto one write target.
    always_comb begin
        kind = K_NONE;
        if (we) begin
            if (addr == MODE_ADDR) begin
                kind = K_MODE;
            end else begin
                unique case (masked)
                    16'h8000, 16'h8800: kind = K_CMD;
                    16'h8001, 16'h8801: kind = K_BANK;
                    16'hA000, 16'hA800: kind = K_MIRROR;
                    default:            kind = K_NONE;
                endcase
            end
        end
    end

    // R10
    wram_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:13] == 3'b011) |-> (kind == K_NONE));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |-> (kind == K_NONE));

endmodule

// File: rtl/smap_scramble.sv
// Bank-number scrambler: passes the written value through, or through the
// pattern or program shuffle when the mode flag is on. Purely combinational.
module smap_scramble
    import smap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_on,
    input  logic  to_prg,
    input  bank_t raw,
    output bank_t cooked
);

    // Pick the rule that matches the mode and the destination slot.
    always_comb begin
        if (!mode_on) begin
            cooked = raw;
        end else if (to_prg) begin
            cooked = shuffle_prg(raw);
        end else begin
            cooked = shuffle_pat(raw);
        end
    end

    // R5
    pat_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && !to_prg) |-> ($countones(cooked) == $countones(raw)));

    // R6
    prg_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_on && to_prg && raw < 8'h20) |-> (cooked < 8'h20));

endmodule

// File: rtl/smap_bank_regs.sv
// Command register and bank slot file. The slot chosen by the command's low
// bits loads the already-scrambled value. Slot PRG_HI resets to 1 so the
// second program window starts at bank 1; every other slot resets to 0.
module smap_bank_regs
    import smap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic                       bank_we,
    input  bank_t                      cmd_data,
    input  bank_t                      bank_data,
    output logic [SEL_W-1:0]           sel,
    output bank_t [NUM_SLOTS-1:0]      slots
);

    bank_t cmd_q;

    // Hold the last command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= cmd_data;
    end

    assign sel = cmd_q[SEL_W-1:0];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam bank_t RST_VAL = (i == PRG_HI) ? bank_t'(1) : bank_t'(0);

        // Load this slot when it is the selected target of a bank write.
        always_ff @(posedge clk) begin
            if (!rst_n)                              slots[i] <= RST_VAL;
            else if (bank_we && sel == SEL_W'(i))    slots[i] <= bank_data;
        end

        // R3
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_we && sel == SEL_W'(i)) |=> $stable(slots[i]));
    end

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q));

endmodule

// File: rtl/scramble_mapper.sv
// Mapper top: write decode, scramble mode flag, mirroring select, bank
// slots and address translation for both memories.
// Assumes PRG_BANKS is a power of two and at least 4; outputs are
// combinational from stored state and the current addresses.
module scramble_mapper
    import smap_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    localparam int PRG_W    = $clog2(PRG_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_wdata,
    input  logic             four_screen,
    input  logic [2:0]       ppu_page,
    output logic [7:0]       chr_bank,
    output logic [PRG_W-1:0] prg_bank,
    output logic             mirror_horiz
);

    localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
    localparam logic [PRG_W-1:0] NEXT_LAST = PRG_W'(PRG_BANKS - 2);

    wr_kind_t              kind;
    logic                  mode_q;
    logic                  mirror_q;
    logic [SEL_W-1:0]      sel;
    bank_t [NUM_SLOTS-1:0] slots;
    bank_t                 cooked;
    bank_t                 pat_base;
    bank_t                 prg_full;

    smap_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_we),
        .addr  (cpu_addr),
        .kind  (kind)
    );

    smap_scramble u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (mode_q),
        .to_prg  (sel >= SEL_W'(PRG_LO)),
        .raw     (cpu_wdata),
        .cooked  (cooked)
    );

    smap_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (kind == K_CMD),
        .bank_we   (kind == K_BANK),
        .cmd_data  (cpu_wdata),
        .bank_data (cooked),
        .sel       (sel),
        .slots     (slots)
    );

    // Scramble mode flag: only two data codes act on it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (kind == K_MODE) begin
            if (cpu_wdata == 8'h00)      mode_q <= 1'b0;
            else if (cpu_wdata == 8'h02) mode_q <= 1'b1;
        end
    end

    // Mirroring select, frozen while the board has four name tables.
    always_ff @(posedge clk) begin
        if (!rst_n)                               mirror_q <= 1'b0;
        else if (kind == K_MIRROR && !four_screen) mirror_q <= cpu_wdata[0];
    end

    assign mirror_horiz = mirror_q;

    // Pattern window to 1 KB bank: lower half pairs, upper half singles.
    always_comb begin
        if (!ppu_page[2]) begin
            pat_base = slots[ppu_page[1]];
            chr_bank = {pat_base[7:1], ppu_page[0]};
        end else begin
            pat_base = '0;
            chr_bank = slots[{1'b0, ppu_page[1:0]} + 3'd2];
        end
    end

    // Program window to 8 KB bank: two switchable, two fixed at the top.
    always_comb begin
        prg_full = '0;
        unique case (cpu_addr[14:13])
            2'd0: begin prg_full = slots[PRG_LO]; prg_bank = prg_full[PRG_W-1:0]; end
            2'd1: begin prg_full = slots[PRG_HI]; prg_bank = prg_full[PRG_W-1:0]; end
            2'd2: prg_bank = NEXT_LAST;
            default: prg_bank = LAST_BANK;
        endcase
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == 16'h5000 && (cpu_wdata == 8'h00 || cpu_wdata == 8'h02))
        |=> $stable(mode_q));

    // R9
    mirror_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        four_screen |=> $stable(mirror_horiz));

    // R8
    fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'd3) |-> (prg_bank == LAST_BANK));

    // R4
    odd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppu_page[2] && ppu_page[0]) |-> chr_bank[0]);

endmodule

// File: tb/sim_scramble_mapper.sv
// Self-checking bench: sweeps every byte through pattern and program slots
// in both modes and probes decode aliases, ignored writes and mirroring.
module sim_scramble_mapper;

    localparam int PRG_BANKS = 16;
    localparam int PRG_W     = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cpu_we = 1'b0;
    logic [15:0]      cpu_addr = 16'h0000;
    logic [7:0]       cpu_wdata = 8'h00;
    logic             four_screen = 1'b0;
    logic [2:0]       ppu_page = 3'd0;
    logic [7:0]       chr_bank;
    logic [PRG_W-1:0] prg_bank;
    logic             mirror_horiz;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    scramble_mapper #(.PRG_BANKS(PRG_BANKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .four_screen(four_screen), .ppu_page(ppu_page),
        .chr_bank(chr_bank), .prg_bank(prg_bank), .mirror_horiz(mirror_horiz)
    );

    // Output bit k takes input bit src[k].
    function automatic logic [7:0] exp_pat(input logic [7:0] v);
        int src[8] = '{0, 1, 3, 7, 6, 2, 4, 5};
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) r[k] = v[src[k]];
        return r;
    endfunction

    function automatic logic [7:0] exp_prg(input logic [7:0] v);
        int src[5] = '{0, 4, 3, 1, 2};
        logic [7:0] r = '0;
        if (v >= 8'h20) return exp_pat(v - 8'h20);
        for (int k = 0; k < 5; k++) r[k] = v[src[k]];
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'h0000;
    endtask

    function automatic int chr_at(input int page);
        return 0;
    endfunction

    task automatic look_chr(input int page, output int val);
        ppu_page = 3'(page); #1; val = chr_bank;
    endtask

    task automatic look_prg(input logic [15:0] a, output int val);
        cpu_addr = a; #1; val = prg_bank; cpu_addr = 16'h0000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every window and the mirroring output
        for (int p = 0; p < 8; p++) begin
            look_chr(p, v);
            check("R1", v, (p < 4) ? (p & 1) : 0);
        end
        look_prg(16'h8000, v); check("R1", v, 0);
        look_prg(16'hA000, v); check("R1", v, 1);
        check("R1", mirror_horiz, 0);

        // R5 R4: full pattern sweep through slot 2 (window 4), both modes
        for (int m = 0; m < 2; m++) begin
            wr(16'h5000, m ? 8'h02 : 8'h00);
            wr(16'h8000, 8'h02);
            for (int d = 0; d < 256; d++) begin
                wr(16'h8001, 8'(d));
                look_chr(4, v);
                check("R5", v, m ? exp_pat(8'(d)) : d);
            end
        end

        // R6 R8: full program sweep through slot 6 and slot 7, both modes, wrapped
        for (int m = 0; m < 2; m++) begin
            wr(16'h5000, m ? 8'h02 : 8'h00);
            for (int d = 0; d < 256; d++) begin
                wr(16'h8000, 8'h06);
                wr(16'h8001, 8'(d));
                wr(16'h8800, 8'hF7);          // alias address, upper command bits ignored
                wr(16'h8801, 8'(255 - d));
                look_prg(16'h8000, v);
                check("R6", v, (m ? exp_prg(8'(d)) : d) % PRG_BANKS);
                look_prg(16'hB000, v);
                check("R8", v, (m ? exp_prg(8'(255 - d)) : 255 - d) % PRG_BANKS);
            end
        end
        look_prg(16'hC000, v); check("R8", v, PRG_BANKS - 2);
        look_prg(16'hFFFF, v); check("R8", v, PRG_BANKS - 1);

        // R4: paired windows from slot 0 and slot 1 with odd and even values
        wr(16'h5000, 8'h00);
        wr(16'h8000, 8'h00); wr(16'h8001, 8'h37);
        wr(16'h8000, 8'h01); wr(16'h8001, 8'h5A);
        look_chr(0, v); check("R4", v, 8'h36);
        look_chr(1, v); check("R4", v, 8'h37);
        look_chr(2, v); check("R4", v, 8'h5A);
        look_chr(3, v); check("R4", v, 8'h5B);
        for (int s = 3; s < 6; s++) begin
            wr(16'h8000, 8'(s)); wr(16'h8001, 8'(8'h10 * s + 1));
        end
        for (int s = 3; s < 6; s++) begin
            look_chr(s + 2, v); check("R4", v, 8'h10 * s + 1);
        end

        // R2: other codes and other addresses leave the mode on
        wr(16'h5000, 8'h02);
        wr(16'h5000, 8'h01); wr(16'h5000, 8'h03); wr(16'h5000, 8'h82);
        wr(16'h5001, 8'h00); wr(16'h6000, 8'h00);
        wr(16'h8000, 8'h03); wr(16'h8001, 8'h80);
        look_chr(5, v); check("R2", v, 8'h08);
        // R2: code 0x00 at 0x5000 turns it off
        wr(16'h5000, 8'h00);
        wr(16'h8001, 8'h80);
        look_chr(5, v); check("R2", v, 8'h80);

        // R7: a stored scrambled value survives a mode change
        wr(16'h5000, 8'h02);
        wr(16'h8000, 8'h05); wr(16'h8001, 8'h80);
        wr(16'h5000, 8'h00);
        look_chr(7, v); check("R7", v, 8'h08);

        // R3: aliases through the 0xFF01 mask, and non-matching addresses
        wr(16'h80FE, 8'h04);                  // masks to 0x8000: command 4
        wr(16'h88FF, 8'h44);                  // masks to 0x8801: slot 4
        look_chr(6, v); check("R3", v, 8'h44);
        wr(16'h8101, 8'h99); wr(16'h9001, 8'h99); wr(16'hC001, 8'h99);
        look_chr(6, v); check("R3", v, 8'h44);
        wr(16'h8100, 8'h02); wr(16'h8001, 8'h66); // 0x8100 ignored: slot 4 still selected
        look_chr(6, v); check("R3", v, 8'h66);
        look_chr(4, v); check("R3", v, 8'hFF);

        // R10: work-RAM range writes leave all state alone
        wr(16'h6000, 8'h02); wr(16'h7FFF, 8'h01); wr(16'h6001, 8'h12); wr(16'h7800, 8'h00);
        look_chr(6, v); check("R10", v, 8'h66);
        wr(16'h8001, 8'h81);                  // mode still off: stored as-is
        look_chr(6, v); check("R10", v, 8'h81);
        check("R10", mirror_horiz, 0);

        // R9: mirroring writes, aliases and the four-screen lock
        wr(16'hA000, 8'h01); check("R9", mirror_horiz, 1);
        wr(16'hA8FE, 8'hFE); check("R9", mirror_horiz, 0);
        wr(16'hA001, 8'h01); check("R9", mirror_horiz, 0);
        four_screen = 1'b1;
        wr(16'hA000, 8'h01); check("R9", mirror_horiz, 0);
        four_screen = 1'b0;
        wr(16'hA800, 8'h03); check("R9", mirror_horiz, 1);

        finish_run();
    end

endmodule